// File: doc/BRIEF.md
# SIMT Warp Divergence Mask Stack

This block tracks which lanes of one warp are enabled while the warp runs through data-dependent branches. The warp issues a single instruction for all of its lanes at once. When the lanes of a branch disagree, the block serialises the two sides. It runs the taken side first, then the not-taken side, and then restores the mask the warp had before the branch at the reconvergence point. Each warp has its own instance, and no state is shared between warps.

The surrounding pipeline loads a new warp with its starting mask and PC. Lanes beyond the end of a partial thread group are simply left out of that mask. For every instruction, the pipeline reports either a plain issue, together with the sequential next PC, or a branch, together with its per-lane outcome and its three candidate PCs. The block answers with the registered active mask and the PC to fetch next. Lanes that terminate are removed permanently, from the running path and from every deferred path.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset, active_mask is all zero, next_pc is zero, stack_level is 1 and overflow is 0.
- R2: A launch loads active_mask from launch_mask and next_pc from launch_pc, sets stack_level to 1 and clears overflow, one cycle later. A launch takes priority over a branch, an issue or an exit presented in the same cycle.
- R3: A plain issue sets next_pc to pc_in and leaves the mask unchanged. A branch on which all live lanes agree pushes nothing. If every live lane is taken, next_pc becomes br_target. If no live lane is taken, next_pc becomes br_fall.
- R4: A divergent branch makes the taken lanes the active mask, with next_pc set to br_target, and raises stack_level by 2. Bit i of every lane vector belongs to lane i.
- R5: When the PC chosen by an issue or a uniform branch equals the reconvergence PC of the running path, and stack_level is above 1, the path is popped. The deferred not-taken path then runs from br_fall with its own lanes. After that path, the pre-branch mask resumes at the reconvergence PC.
- R6: A side whose start PC equals the reconvergence PC is not pushed, so stack_level rises by only 1. When the taken side is skipped in this way, the not-taken side runs first.
- R7: An exit clears the named lanes in the running mask and in every stacked mask. When the running path is left with no lanes and stack_level is above 1, the path is popped in that same cycle.
- R8: A divergent branch that needs more entries than remain within DEPTH leaves the stack, the mask and the PC unchanged, and sets overflow. Overflow stays set until reset or the next launch.
- R9: Taken bits on lanes that are not in the active mask have no effect, and a branch whose mask is empty changes nothing.
- R10: In a cycle with no launch, issue, branch or exit, the mask, the PC and the level all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Start a new warp |
| launch_mask | input | LANES | Lanes present in the new warp |
| launch_pc | input | PCW | Start PC of the new warp |
| issue | input | 1 | Non-branch instruction issued |
| pc_in | input | PCW | Sequential next PC for an issue |
| br_valid | input | 1 | Branch instruction issued |
| br_taken | input | LANES | Per-lane branch outcome |
| br_target | input | PCW | Taken-side PC |
| br_fall | input | PCW | Not-taken-side PC |
| br_reconv | input | PCW | Reconvergence PC of the branch |
| exit_lanes | input | LANES | Lanes terminating this cycle |
| active_mask | output | LANES | Lanes enabled for the next instruction |
| next_pc | output | PCW | PC of the next instruction |
| stack_level | output | $clog2(DEPTH+1) | Number of stack entries in use |
| overflow | output | 1 | Sticky stack overflow flag |

## Verification
The bench builds the block with 4 lanes, 8-bit PCs and a depth of 4. With 4 lanes, every pairing of launch mask and taken vector can be swept: 256 cases, covering the empty mask, the uniform outcomes in both directions, and every divergent split, each followed through both pops. With a depth of 4, a second nested divergence already reaches the limit. That makes the overflow case and the single-entry nested push reachable with a few directed sequences, which also exercise exits that empty a path.

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
  parameter int LANES = 32,
  parameter int PCW   = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         launch,
  input  logic [LANES-1:0]             launch_mask,
  input  logic [PCW-1:0]               launch_pc,
  input  logic                         issue,
  input  logic [PCW-1:0]               pc_in,
  input  logic                         br_valid,
  input  logic [LANES-1:0]             br_taken,
  input  logic [PCW-1:0]               br_target,
  input  logic [PCW-1:0]               br_fall,
  input  logic [PCW-1:0]               br_reconv,
  input  logic [LANES-1:0]             exit_lanes,
  output logic [LANES-1:0]             active_mask,
  output logic [PCW-1:0]               next_pc,
  output logic [$clog2(DEPTH+1)-1:0]   stack_level,
  output logic                         overflow
);
  localparam int SPW = $clog2(DEPTH+1);

  logic [LANES-1:0] mask_q [DEPTH];
  logic [PCW-1:0]   pc_q   [DEPTH];
  logic [PCW-1:0]   rpc_q  [DEPTH];
  logic [LANES-1:0] mask_d [DEPTH];
  logic [PCW-1:0]   pc_d   [DEPTH];
  logic [PCW-1:0]   rpc_d  [DEPTH];
  logic [SPW-1:0]   sp_q, sp_d;
  logic             ovf_q, ovf_d;

  logic [LANES-1:0] top_mask, live_top, tk_m, nt_m;
  logic [PCW-1:0]   top_pc, top_rpc, new_pc;
  logic             need_nt, need_tk, diverge, room;
  logic [1:0]       push_n;

  always_comb begin
    top_mask = '0;
    top_pc   = '0;
    top_rpc  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i == int'(sp_q) - 1) begin
        top_mask = mask_q[i];
        top_pc   = pc_q[i];
        top_rpc  = rpc_q[i];
      end
    end
  end

  assign live_top = top_mask & ~exit_lanes;
  assign tk_m     = br_taken & live_top;
  assign nt_m     = live_top & ~br_taken;
  assign need_nt  = br_fall != br_reconv;
  assign need_tk  = br_target != br_reconv;
  assign push_n   = {1'b0, need_nt} + {1'b0, need_tk};
  assign diverge  = br_valid && (tk_m != '0) && (nt_m != '0);
  assign room     = (int'(sp_q) + int'(push_n)) <= DEPTH;
  assign new_pc   = br_valid ? ((tk_m != '0) ? br_target : br_fall) : pc_in;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mask_d[i] = mask_q[i] & ~exit_lanes;
      pc_d[i]   = pc_q[i];
      rpc_d[i]  = rpc_q[i];
    end
    sp_d  = sp_q;
    ovf_d = ovf_q;
    if (launch) begin
      for (int i = 0; i < DEPTH; i++) begin
        mask_d[i] = '0;
        pc_d[i]   = '0;
        rpc_d[i]  = '0;
      end
      mask_d[0] = launch_mask;
      pc_d[0]   = launch_pc;
      sp_d      = SPW'(1);
      ovf_d     = 1'b0;
    end else if (live_top == '0) begin
      if (sp_q > SPW'(1)) sp_d = sp_q - SPW'(1);
    end else if (diverge) begin
      if (!room) begin
        ovf_d = 1'b1;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (i == int'(sp_q) - 1) pc_d[i] = br_reconv;
          if (need_nt && i == int'(sp_q)) begin
            mask_d[i] = nt_m;
            pc_d[i]   = br_fall;
            rpc_d[i]  = br_reconv;
          end
          if (need_tk && i == int'(sp_q) + int'(need_nt)) begin
            mask_d[i] = tk_m;
            pc_d[i]   = br_target;
            rpc_d[i]  = br_reconv;
          end
        end
        sp_d = SPW'(int'(sp_q) + int'(push_n));
      end
    end else if (br_valid || issue) begin
      if (sp_q > SPW'(1) && new_pc == top_rpc) begin
        sp_d = sp_q - SPW'(1);
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if (i == int'(sp_q) - 1) pc_d[i] = new_pc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mask_q[i] <= '0;
        pc_q[i]   <= '0;
        rpc_q[i]  <= '0;
      end
      sp_q  <= SPW'(1);
      ovf_q <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        mask_q[i] <= mask_d[i];
        pc_q[i]   <= pc_d[i];
        rpc_q[i]  <= rpc_d[i];
      end
      sp_q  <= sp_d;
      ovf_q <= ovf_d;
    end
  end

  assign active_mask = top_mask;
  assign next_pc     = top_pc;
  assign stack_level = sp_q;
  assign overflow    = ovf_q;

  a_r2_launch_loads: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> active_mask == $past(launch_mask) && next_pc == $past(launch_pc)
               && stack_level == SPW'(1) && !overflow);

  a_r3_uniform_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && !launch &&
    (((br_taken & active_mask & ~exit_lanes) == '0) || ((~br_taken & active_mask & ~exit_lanes) == '0))
    |=> stack_level <= $past(stack_level));

  a_r4_taken_first: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && !launch && br_target != br_reconv && br_fall != br_reconv &&
    (br_taken & active_mask & ~exit_lanes) != '0 && (~br_taken & active_mask & ~exit_lanes) != '0 &&
    int'(stack_level) + 2 <= DEPTH
    |=> active_mask == $past(br_taken & active_mask & ~exit_lanes) && next_pc == $past(br_target));

  a_r7_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !launch && exit_lanes != '0 |=> (active_mask & $past(exit_lanes)) == '0);

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !launch |=> overflow);

  a_r8_overflow_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $stable(stack_level));
endmodule

// File: tb/test_simt_mask_stack.sv
`timescale 1ns/1ps
module test_simt_mask_stack;
  localparam int L = 4, P = 8, D = 4;
  logic clk = 0, rst_n = 0;
  logic launch = 0, issue = 0, br_valid = 0;
  logic [L-1:0] launch_mask = '0, br_taken = '0, exit_lanes = '0;
  logic [P-1:0] launch_pc = '0, pc_in = '0, br_target = '0, br_fall = '0, br_reconv = '0;
  logic [L-1:0] active_mask;
  logic [P-1:0] next_pc;
  logic [2:0]   stack_level;
  logic         overflow;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  simt_mask_stack #(.LANES(L), .PCW(P), .DEPTH(D)) i_simt_mask_stack (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_mask(launch_mask), .launch_pc(launch_pc),
    .issue(issue), .pc_in(pc_in), .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
    .br_fall(br_fall), .br_reconv(br_reconv), .exit_lanes(exit_lanes),
    .active_mask(active_mask), .next_pc(next_pc), .stack_level(stack_level), .overflow(overflow));

  always #2 clk = ~clk;

  task automatic cyc();
    @(posedge clk); #1;
    launch = 0; issue = 0; br_valid = 0; exit_lanes = '0;
  endtask

  task automatic do_launch(input logic [L-1:0] m, input logic [P-1:0] pc);
    launch = 1; launch_mask = m; launch_pc = pc; cyc();
  endtask
  task automatic do_issue(input logic [P-1:0] pc);
    issue = 1; pc_in = pc; cyc();
  endtask
  task automatic do_branch(input logic [L-1:0] t, input logic [P-1:0] tg, fl, rc);
    br_valid = 1; br_taken = t; br_target = tg; br_fall = fl; br_reconv = rc; cyc();
  endtask
  task automatic do_exit(input logic [L-1:0] e);
    exit_lanes = e; cyc();
  endtask

  task automatic chk(input string req, input logic [L-1:0] em, input logic [P-1:0] ep,
                     input int el, input bit eo);
    n_chk++;
    if (active_mask !== em || next_pc !== ep || int'(stack_level) != el || overflow !== eo) begin
      n_bad++;
      $display("FAIL %s: got mask=%h pc=%h lvl=%0d ovf=%b, expected mask=%h pc=%h lvl=%0d ovf=%b",
               req, active_mask, next_pc, stack_level, overflow, em, ep, el, eo);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    chk("R1 reset", '0, '0, 1, 0);

    for (int m = 0; m < 16; m++) begin
      for (int t = 0; t < 16; t++) begin
        logic [L-1:0] mm, tk, nt;
        mm = L'(m); tk = L'(t) & mm; nt = mm & ~L'(t);
        do_launch(mm, 8'h10);
        chk("R2 launch", mm, 8'h10, 1, 0);
        do_branch(L'(t), 8'h40, 8'h11, 8'h50);
        if (mm == '0) chk("R9 empty mask", '0, 8'h10, 1, 0);
        else if (tk == '0) chk("R3 R9 uniform not taken", mm, 8'h11, 1, 0);
        else if (nt == '0) chk("R3 R9 uniform taken", mm, 8'h40, 1, 0);
        else begin
          chk("R4 taken first", tk, 8'h40, 3, 0);
          do_issue(8'h50);
          chk("R5 not-taken path", nt, 8'h11, 2, 0);
          do_issue(8'h50);
          chk("R5 reconverged", mm, 8'h50, 1, 0);
        end
        if (mm != '0) begin
          do_issue(8'h77);
          chk("R3 issue", mm, 8'h77, 1, 0);
        end
      end
    end

    do_launch(4'hF, 8'h00);
    do_branch(4'b0011, 8'h20, 8'h50, 8'h50);
    chk("R6 not-taken skipped", 4'b0011, 8'h20, 2, 0);
    do_issue(8'h50);
    chk("R6 reconverge", 4'hF, 8'h50, 1, 0);
    do_branch(4'b0011, 8'h50, 8'h21, 8'h50);
    chk("R6 taken skipped", 4'b1100, 8'h21, 2, 0);
    do_issue(8'h22);
    chk("R3 issue on path", 4'b1100, 8'h22, 2, 0);
    do_issue(8'h50);
    chk("R6 reconverge 2", 4'hF, 8'h50, 1, 0);
    do_exit('0);
    chk("R10 idle holds", 4'hF, 8'h50, 1, 0);

    do_launch(4'hF, 8'h00);
    do_branch(4'b0011, 8'h30, 8'h31, 8'h60);
    chk("R4 diverge", 4'b0011, 8'h30, 3, 0);
    do_exit(4'b0001);
    chk("R7 exit one", 4'b0010, 8'h30, 3, 0);
    do_exit(4'b0010);
    chk("R7 empty path pops", 4'b1100, 8'h31, 2, 0);
    do_issue(8'h60);
    chk("R7 stacked mask cleared", 4'b1100, 8'h60, 1, 0);

    do_launch(4'hF, 8'h00);
    do_branch(4'b0101, 8'h40, 8'h41, 8'h70);
    chk("R4 diverge", 4'b0101, 8'h40, 3, 0);
    do_branch(4'b0001, 8'h42, 8'h43, 8'h44);
    chk("R8 overflow", 4'b0101, 8'h40, 3, 1);
    do_issue(8'h45);
    chk("R8 sticky", 4'b0101, 8'h45, 3, 1);
    do_launch(4'b0011, 8'h08);
    chk("R2 launch clears overflow", 4'b0011, 8'h08, 1, 0);

    do_launch(4'hF, 8'h00);
    do_branch(4'b0011, 8'h10, 8'h11, 8'h20);
    do_branch(4'b0001, 8'h12, 8'h13, 8'h13);
    chk("R6 nested single push", 4'b0001, 8'h12, 4, 0);
    do_issue(8'h13);
    chk("R5 inner reconverge", 4'b0011, 8'h13, 3, 0);
    do_issue(8'h20);
    chk("R5 outer not-taken", 4'b1100, 8'h11, 2, 0);
    do_issue(8'h20);
    chk("R5 outer reconverge", 4'hF, 8'h20, 1, 0);

    launch = 1; launch_mask = 4'b0110; launch_pc = 8'h90;
    br_valid = 1; br_taken = 4'b0010; br_target = 8'h91; br_fall = 8'h92; br_reconv = 8'h93;
    exit_lanes = 4'b0100;
    cyc();
    chk("R2 launch priority", 4'b0110, 8'h90, 1, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule